// File: doc/BRIEF.md
# Processor mode and privilege controller

This block holds the execution context of a small processor core. It reports whether the core is running ordinary code (thread mode) or an exception handler (handler mode), and whether the current code is privileged or unprivileged. It also chooses which of two banked stack pointers, main or process, is visible, and presents the word-aligned value of that pointer.

Software changes the thread-level context through a control write. The write carries two fields: a "drop privilege" bit and a "use process stack" bit. Unprivileged code can lower its own rights but can never raise them. Only an exception gets back to privileged execution. Exceptions nest. A counter records how deep the nesting is, so that only the return from the outermost handler restores thread mode. Thread mode comes back with the privilege and stack choice it had before, unless a handler rewrote them while it ran.

Instruction decode, the actual saving of registers on the stack, and memory-protection checks are outside this block.

Top module: `mode_priv_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`mode_o`=0, 1 means handler), privileged (`priv_o`=1, 1 means privileged), on the main stack (`spsel_o`=0, 1 means process), and `sp_o` shows the main pointer's reset value.
- R2: In privileged thread mode, a control write with `ctl_npriv`=1 makes `priv_o` read 0 from the next cycle on. The `ctl_spsel` field of the same write sets the thread stack choice.
- R3: In unprivileged thread mode, the `ctl_npriv` field of a control write is ignored, so `priv_o` stays 0. The `ctl_spsel` field still updates the thread stack choice.
- R4: The cycle after an exception entry strobe, `mode_o`=1 and `priv_o`=1, whatever the earlier state was.
- R5: While `mode_o`=1, `spsel_o`=0 and `sp_o` shows the main pointer, whatever stack choice is stored.
- R6: Returning from the outermost exception restores the thread privilege and stack choice that were stored before the entry.
- R7: A nesting counter of 2^DEPTH_W-1 levels tracks entries. Only the return that brings it to zero leaves handler mode. At full depth, further entries are ignored.
- R8: A control write made in handler mode does not change `priv_o` or `spsel_o` while the handler runs. It sets the thread privilege (and may raise it) and the stack choice that take effect on exit.
- R9: Both stack pointers always read with bits [1:0] zero; the low two bits of a written value are dropped. A pointer write targets only the pointer that is visible in that cycle.
- R10: An exception return strobe in thread mode has no effect.
- R11: An entry and a return strobe in the same cycle leave the nesting depth unchanged when both take effect. In thread mode the return is ignored and the entry proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_npriv | input | 1 | Write data: 1 requests unprivileged thread execution |
| ctl_spsel | input | 1 | Write data: 1 selects the process stack in thread mode |
| sp_wr | input | 1 | Write strobe for the visible stack pointer |
| sp_wdata | input | SP_W | Stack pointer write value |
| mode_o | output | 1 | 1 = handler mode, 0 = thread mode |
| priv_o | output | 1 | 1 = privileged |
| spsel_o | output | 1 | 1 = process stack visible |
| sp_o | output | SP_W | Aligned value of the visible stack pointer |

## Verification
If the nesting counter is wrong, `mode_o` falls back to thread mode one return too early or one too late. That shows on the cycle after the return strobe. A stored privilege that is wrongly raised or lowered stays hidden while a handler runs. It shows on `priv_o` one cycle after the outermost return. A wrong stack pointer write lands in the hidden bank, so `sp_o` only reveals it after the next mode or stack-choice change. The bench therefore follows each such update with a switch that exposes it.

// File: rtl/mpc_pkg.sv
// Shared types for the mode and privilege controller.
package mpc_pkg;

    // Execution mode of the core
    typedef enum logic {
        MODE_THREAD  = 1'b0,
        MODE_HANDLER = 1'b1
    } mode_e;

    // Stored thread-level control fields
    typedef struct packed {
        logic npriv;  // 1 = unprivileged thread execution
        logic spsel;  // 1 = process stack in thread mode
    } ctl_t;

endpackage

// File: rtl/mpc_nest_counter.sv
// Exception nesting counter.
// Counts accepted exception entries minus accepted returns.
// Assumes: entry is refused at full depth; return is refused at depth zero;
// when both are accepted in one cycle the depth stays as it is.
module mpc_nest_counter #(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enter,
    input  logic               leave,
    output logic [DEPTH_W-1:0] depth,
    output logic               in_handler
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};

    logic take_in;
    logic take_out;

    // Decide which strobes are accepted at the present depth
    always_comb begin
        take_in  = enter && (depth != DEPTH_MAX);
        take_out = leave && (depth != '0);
    end

    // Update the depth register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (take_in && !take_out) begin
            depth <= depth + 1'b1;
        end else if (take_out && !take_in) begin
            depth <= depth - 1'b1;
        end
    end

    assign in_handler = (depth != '0);

endmodule

// File: rtl/mpc_ctrl_reg.sv
// Thread-level control register holding the privilege and stack choice.
// Assumes: the privilege field can be raised only when the current code is
// privileged (handler mode, or thread mode that is already privileged).
module mpc_ctrl_reg
    import mpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  ctl_t wdata,
    input  logic in_handler,
    output ctl_t q
);
    logic code_privileged;

    // Privilege held by the code that issues the write
    assign code_privileged = in_handler || !q.npriv;

    // Store the accepted fields of a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q.spsel <= wdata.spsel;
            if (code_privileged) begin
                q.npriv <= wdata.npriv;
            end
        end
    end

endmodule

// File: rtl/mpc_sp_bank.sv
// Two banked stack pointers (index 0 main, index 1 process).
// Assumes: only the selected bank is written; values are stored with the low
// ALIGN_BITS cleared, so every read is word aligned.
module mpc_sp_bank #(
    parameter int          SP_W       = 32,
    parameter int          ALIGN_BITS = 2,
    parameter logic [31:0] MAIN_INIT  = 32'h2000_0400,
    parameter logic [31:0] PROC_INIT  = 32'h2000_0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic [SP_W-1:0] wdata,
    output logic [SP_W-1:0] rdata
);
    localparam int NUM_BANKS = 2;
    localparam logic [SP_W-1:0] ALIGN_MASK = ~{{(SP_W-ALIGN_BITS){1'b0}}, {ALIGN_BITS{1'b1}}};

    logic [SP_W-1:0] bank_q [NUM_BANKS];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        localparam logic [SP_W-1:0] INIT_V = (i == 0) ? MAIN_INIT[SP_W-1:0] : PROC_INIT[SP_W-1:0];

        // Hold one pointer; accept writes only while this bank is visible
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[i] <= INIT_V & ALIGN_MASK;
            end else if (wr && (sel == 1'(i))) begin
                bank_q[i] <= wdata & ALIGN_MASK;
            end
        end
    end

    // Present the visible pointer
    assign rdata = bank_q[sel] & ALIGN_MASK;

endmodule

// File: rtl/mode_priv_ctrl.sv
// Processor mode and privilege controller (top).
// Combines the nesting counter, the control register and the stack bank.
// Assumes: handler mode is always privileged and always uses the main stack.
module mode_priv_ctrl
    import mpc_pkg::*;
#(
    parameter int          SP_W      = 32,
    parameter int          DEPTH_W   = 4,
    parameter logic [31:0] MAIN_INIT = 32'h2000_0400,
    parameter logic [31:0] PROC_INIT = 32'h2000_0800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_enter,
    input  logic            exc_return,
    input  logic            ctl_wr,
    input  logic            ctl_npriv,
    input  logic            ctl_spsel,
    input  logic            sp_wr,
    input  logic [SP_W-1:0] sp_wdata,
    output logic            mode_o,
    output logic            priv_o,
    output logic            spsel_o,
    output logic [SP_W-1:0] sp_o
);
    logic [DEPTH_W-1:0] depth;
    logic               in_handler;
    ctl_t               ctl_q;
    ctl_t               ctl_wdata;
    mode_e              cur_mode;

    assign ctl_wdata = '{npriv: ctl_npriv, spsel: ctl_spsel};

    mpc_nest_counter #(.DEPTH_W(DEPTH_W)) u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (exc_enter),
        .leave      (exc_return),
        .depth      (depth),
        .in_handler (in_handler)
    );

    mpc_ctrl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctl_wr),
        .wdata      (ctl_wdata),
        .in_handler (in_handler),
        .q          (ctl_q)
    );

    // Derive mode, effective privilege and stack choice
    always_comb begin
        cur_mode = in_handler ? MODE_HANDLER : MODE_THREAD;
        mode_o   = (cur_mode == MODE_HANDLER);
        priv_o   = (cur_mode == MODE_HANDLER) || !ctl_q.npriv;
        spsel_o  = (cur_mode == MODE_THREAD) && ctl_q.spsel;
    end

    mpc_sp_bank #(
        .SP_W      (SP_W),
        .ALIGN_BITS(2),
        .MAIN_INIT (MAIN_INIT),
        .PROC_INIT (PROC_INIT)
    ) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (spsel_o),
        .wr    (sp_wr),
        .wdata (sp_wdata),
        .rdata (sp_o)
    );

endmodule

// File: rtl/mpc_chk.sv
// Property checker for the mode and privilege controller, bound to the top.
module mpc_chk #(
    parameter int SP_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_enter,
    input logic            exc_return,
    input logic            mode_o,
    input logic            priv_o,
    input logic            spsel_o,
    input logic [SP_W-1:0] sp_o
);
    // R3
    user_stays_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && !priv_o && !exc_enter) |=> !priv_o);

    // R4
    entry_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (mode_o && priv_o));

    // R5
    handler_main_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> !spsel_o);

    // R9
    sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o[1:0] == 2'b00);

    // R10
    thread_return_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && exc_return && !exc_enter) |=> !mode_o);

    // R7
    leave_handler_only_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o && !exc_return) |=> mode_o);
endmodule

bind mode_priv_ctrl mpc_chk #(.SP_W(SP_W)) u_mpc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .mode_o     (mode_o),
    .priv_o     (priv_o),
    .spsel_o    (spsel_o),
    .sp_o       (sp_o)
);

// File: tb/test_mode_priv_ctrl.sv
// Bench for mode_priv_ctrl: vector table walk, then directed corner tests.
module test_mode_priv_ctrl;
    localparam int SP_W = 32;
    localparam logic [31:0] MAIN_RST = 32'h2000_0400;
    localparam logic [31:0] PROC_RST = 32'h2000_0800;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exc_enter = 1'b0, exc_return = 1'b0;
    logic            ctl_wr = 1'b0, ctl_npriv = 1'b0, ctl_spsel = 1'b0;
    logic            sp_wr = 1'b0;
    logic [SP_W-1:0] sp_wdata = '0;
    logic            mode_o, priv_o, spsel_o;
    logic [SP_W-1:0] sp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mode_priv_ctrl i_mode_priv_ctrl (
        .clk, .rst_n, .exc_enter, .exc_return, .ctl_wr, .ctl_npriv,
        .ctl_spsel, .sp_wr, .sp_wdata, .mode_o, .priv_o, .spsel_o, .sp_o
    );

    typedef struct packed {
        logic        en, rt, wr, np, ss, spw;
        logic [31:0] spd;
        logic        em, ep, es;
        logic [31:0] esp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        // en rt wr np ss spw  spd           em ep es  esp
        '{0,0,0,0,0,0, 32'h0,          0,1,0, 32'h2000_0400, 8'd1},  // R1 idle
        '{0,0,0,0,0,1, 32'h1000_0007,  0,1,0, 32'h1000_0004, 8'd9},  // R9 main write aligned
        '{0,0,1,0,1,0, 32'h0,          0,1,1, 32'h2000_0800, 8'd2},  // R2 choose process stack
        '{0,0,0,0,0,1, 32'h3000_00FF,  0,1,1, 32'h3000_00FC, 8'd9},  // R9 process write aligned
        '{0,0,1,1,1,0, 32'h0,          0,0,1, 32'h3000_00FC, 8'd2},  // R2 drop privilege
        '{0,0,1,0,1,0, 32'h0,          0,0,1, 32'h3000_00FC, 8'd3},  // R3 raise refused
        '{1,0,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0004, 8'd4},  // R4 R5 entry
        '{0,0,0,0,0,1, 32'h1000_0102,  1,1,0, 32'h1000_0100, 8'd5},  // R5 write goes to main
        '{1,0,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd7},  // R7 nest to two
        '{0,1,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd7},  // R7 inner return
        '{0,1,0,0,0,0, 32'h0,          0,0,1, 32'h3000_00FC, 8'd6},  // R6 outer return restores
        '{0,1,0,0,0,0, 32'h0,          0,0,1, 32'h3000_00FC, 8'd10}, // R10 stray return
        '{1,0,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd4},  // R4 entry from user
        '{0,0,1,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd8},  // R8 handler rewrites thread ctl
        '{0,1,0,0,0,0, 32'h0,          0,1,0, 32'h1000_0100, 8'd8},  // R8 exit with raised privilege
        '{1,1,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd11}, // R11 both in thread
        '{1,1,0,0,0,0, 32'h0,          1,1,0, 32'h1000_0100, 8'd11}, // R11 both in handler
        '{0,1,0,0,0,0, 32'h0,          0,1,0, 32'h1000_0100, 8'd11}, // R11 depth was one
        '{0,0,1,1,0,0, 32'h0,          0,0,0, 32'h1000_0100, 8'd2},  // R2 drop, main stack
        '{0,0,1,1,1,0, 32'h0,          0,0,1, 32'h3000_00FC, 8'd3}   // R3 user may pick stack
    };

    task automatic check(input logic em, ep, es, input logic [31:0] esp, input int req);
        n_chk++;
        if ({mode_o, priv_o, spsel_o, sp_o} !== {em, ep, es, esp}) begin
            n_bad++;
            $display("FAIL R%0d: mode/priv/spsel/sp = %b/%b/%b/%h expected %b/%b/%b/%h",
                     req, mode_o, priv_o, spsel_o, sp_o, em, ep, es, esp);
        end
    endtask

    task automatic drive(input logic en, rt, wr, np, ss, spw, input logic [31:0] spd);
        exc_enter = en; exc_return = rt; ctl_wr = wr; ctl_npriv = np;
        ctl_spsel = ss; sp_wr = spw; sp_wdata = spd;
        @(negedge clk);
        exc_enter = 0; exc_return = 0; ctl_wr = 0; sp_wr = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(0, 1, 0, MAIN_RST, 1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].en, VEC[i].rt, VEC[i].wr, VEC[i].np, VEC[i].ss, VEC[i].spw, VEC[i].spd);
            check(VEC[i].em, VEC[i].ep, VEC[i].es, VEC[i].esp, int'(VEC[i].req));
        end

        // R7 saturation: 16 entries count only 15 levels
        for (int k = 0; k < 16; k++) drive(1, 0, 0, 0, 0, 0, 0);
        check(1, 1, 0, 32'h1000_0100, 7);
        for (int k = 0; k < 14; k++) drive(0, 1, 0, 0, 0, 0, 0);
        check(1, 1, 0, 32'h1000_0100, 7);
        drive(0, 1, 0, 0, 0, 0, 0);
        check(0, 0, 1, 32'h3000_00FC, 7);

        // R4 entry from user thread on the process stack
        drive(1, 0, 0, 0, 0, 0, 0);
        check(1, 1, 0, 32'h1000_0100, 4);
        drive(0, 1, 0, 0, 0, 0, 0);

        // R1 reset again from a modified state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(0, 1, 0, MAIN_RST, 1);
        drive(0, 0, 1, 0, 1, 0, 0);
        check(0, 1, 1, PROC_RST, 1);

        done = 1'b1;
        finish_run();
    end
endmodule